// File: doc/BRIEF.md
# Funnel Shifter With Shift Modes

This block is a purely combinational word shifter that handles four kinds of shift through one shared datapath. A selection stage places a high word and a low word side by side to form a double-width window, then picks a right-extraction offset. A chain of logarithmic 2:1 multiplexer stages moves the window right by that offset, and the lower word of the window is the result. The choice of the two words and the offset is all that separates a logical right shift, an arithmetic right shift, a logical left shift and a right rotate.

The shift distance comes either from a short constant field (as an instruction immediate would supply it) or from a full-width register value, of which only the low bits count. The block sits in an execute stage next to the adder. The caller holds the operand, the amount sources and the operation steady, and the result settles within the same cycle.

Top module: `funnel_shifter`

## Requirements
- R1: With `op_i` = 2'b00 (logical right), `res_o` equals the operand shifted right by k, where k is the selected amount. The k vacated upper bits are 0.
- R2: With `op_i` = 2'b01 (arithmetic right), `res_o` equals the operand shifted right by k. The vacated upper bits are copies of operand bit 31, so `res_o[31]` always equals `opnd_i[31]`.
- R3: With `op_i` = 2'b10 (logical left), `res_o` equals the operand shifted left by k. The k vacated lower bits are 0.
- R4: With `op_i` = 2'b11 (rotate right), `res_o` bit i equals operand bit (i+k) mod 32.
- R5: When k is 0, `res_o` equals `opnd_i` for all four operations.
- R6: When `amt_sel_i` is 0, k is `imm_amt_i`. When `amt_sel_i` is 1, k is `reg_amt_i[4:0]`, and bits 31:5 of `reg_amt_i` have no effect on `res_o`.
- R7: A rotate never changes the number of set bits: `res_o` has as many ones as `opnd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Data word to be shifted |
| imm_amt_i | input | 5 | Shift distance taken from a constant field |
| reg_amt_i | input | 32 | Register value whose low 5 bits may give the distance |
| amt_sel_i | input | 1 | 0 selects `imm_amt_i`, 1 selects `reg_amt_i[4:0]` |
| op_i | input | 2 | 00 logical right, 01 arithmetic right, 10 logical left, 11 rotate right |
| res_o | output | 32 | Shifted or rotated word |

## Verification
The bound checker re-evaluates the fill rules whenever any input changes. It confirms zero fill for logical shifts in both directions, sign retention for arithmetic shifts, bit-count preservation for rotates, and the identity result at distance zero. Those properties cannot show that every bit lands in the right position, or that the upper register bits are ignored. Those come only from the bench's sweep of every operation and distance over a set of operand patterns, driven from both amount sources, with junk in the unused register bits, and compared against arithmetic reference values.

// File: rtl/funnel_shifter_pkg.sv
package funnel_shifter_pkg;

    typedef enum logic [1:0] {
        OP_SRL = 2'b00,
        OP_SRA = 2'b01,
        OP_SLL = 2'b10,
        OP_ROR = 2'b11
    } shift_op_e;

endpackage

// File: rtl/funnel_select.sv
module funnel_select
    import funnel_shifter_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   opnd_i,
    input  logic [1:0]     op_i,
    input  logic [SHW-1:0] amt_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o,
    output logic [SHW-1:0] ofs_o
);

    typedef struct packed {
        logic [W-1:0]   hi;
        logic [W-1:0]   lo;
        logic [SHW-1:0] ofs;
    } win_t;

    win_t win_d;

    always_comb begin
        win_d.hi  = '0;
        win_d.lo  = opnd_i;
        win_d.ofs = amt_i;
        case (shift_op_e'(op_i))
            OP_SRL: begin
                win_d.hi = '0;
            end
            OP_SRA: begin
                win_d.hi = {W{opnd_i[W-1]}};
            end
            OP_SLL: begin
                // Left by k is a right extraction at W-k from {opnd, 0};
                // k = 0 falls back to the plain operand at offset 0.
                if (amt_i != '0) begin
                    win_d.hi  = opnd_i;
                    win_d.lo  = '0;
                    win_d.ofs = ~amt_i + 1'b1;
                end
            end
            default: begin
                win_d.hi = opnd_i;
            end
        endcase
    end

    assign hi_o  = win_d.hi;
    assign lo_o  = win_d.lo;
    assign ofs_o = win_d.ofs;

endmodule

// File: rtl/funnel_stage.sv
module funnel_stage #(
    parameter int WW   = 64,
    parameter int STEP = 1
) (
    input  logic [WW-1:0] win_i,
    input  logic          en_i,
    output logic [WW-1:0] win_o
);

    logic [WW-1:0] win_d;

    always_comb begin
        win_d = en_i ? (win_i >> STEP) : win_i;
    end

    assign win_o = win_d;

endmodule

// File: rtl/funnel_core.sv
module funnel_core #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   hi_i,
    input  logic [W-1:0]   lo_i,
    input  logic [SHW-1:0] ofs_i,
    output logic [W-1:0]   res_o
);

    localparam int WW = 2 * W;

    logic [WW-1:0] chain_d [SHW+1];

    assign chain_d[0] = {hi_i, lo_i};

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        funnel_stage #(
            .WW  (WW),
            .STEP(1 << s)
        ) u_stage (
            .win_i(chain_d[s]),
            .en_i (ofs_i[s]),
            .win_o(chain_d[s+1])
        );
    end

    logic [W-1:0] unused_core_top;
    assign unused_core_top = chain_d[SHW][WW-1:W];
    assign res_o           = chain_d[SHW][W-1:0];

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import funnel_shifter_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   opnd_i,
    input  logic [SHW-1:0] imm_amt_i,
    input  logic [W-1:0]   reg_amt_i,
    input  logic           amt_sel_i,
    input  logic [1:0]     op_i,
    output logic [W-1:0]   res_o
);

    logic [SHW-1:0] amt_d;
    logic [W-1:0]   hi_d;
    logic [W-1:0]   lo_d;
    logic [SHW-1:0] ofs_d;
    logic           unused_amt_hi;

    always_comb begin
        amt_d = amt_sel_i ? reg_amt_i[SHW-1:0] : imm_amt_i;
    end

    assign unused_amt_hi = ^reg_amt_i[W-1:SHW];

    funnel_select #(.W(W), .SHW(SHW)) u_select (
        .opnd_i(opnd_i),
        .op_i  (op_i),
        .amt_i (amt_d),
        .hi_o  (hi_d),
        .lo_o  (lo_d),
        .ofs_o (ofs_d)
    );

    funnel_core #(.W(W), .SHW(SHW)) u_core (
        .hi_i (hi_d),
        .lo_i (lo_d),
        .ofs_i(ofs_d),
        .res_o(res_o)
    );

endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input logic [W-1:0]   opnd_i,
    input logic [SHW-1:0] imm_amt_i,
    input logic [W-1:0]   reg_amt_i,
    input logic           amt_sel_i,
    input logic [1:0]     op_i,
    input logic [W-1:0]   res_o
);

    logic [SHW-1:0] k_c;
    logic [W-1:0]   top_mask_c;
    logic [W-1:0]   low_mask_c;
    logic           unused_chk;

    assign unused_chk = ^reg_amt_i[W-1:SHW];

    always_comb begin
        k_c        = amt_sel_i ? reg_amt_i[SHW-1:0] : imm_amt_i;
        top_mask_c = ~({W{1'b1}} >> k_c);
        low_mask_c = ~({W{1'b1}} << k_c);

        if (op_i == 2'b00)
            p_srl_zero_fill_r1: assert ((res_o & top_mask_c) == '0);
        if (op_i == 2'b01)
            p_sra_sign_kept_r2: assert (res_o[W-1] == opnd_i[W-1]);
        if (op_i == 2'b10)
            p_sll_zero_fill_r3: assert ((res_o & low_mask_c) == '0);
        if (k_c == '0)
            p_zero_amount_identity_r5: assert (res_o == opnd_i);
        if (op_i == 2'b11)
            p_ror_popcount_r7: assert ($countones(res_o) == $countones(opnd_i));
    end

endmodule

bind funnel_shifter funnel_shifter_chk #(.W(W), .SHW(SHW)) u_chk (
    .opnd_i   (opnd_i),
    .imm_amt_i(imm_amt_i),
    .reg_amt_i(reg_amt_i),
    .amt_sel_i(amt_sel_i),
    .op_i     (op_i),
    .res_o    (res_o)
);

// File: tb/funnel_shifter_bench.sv
module funnel_shifter_bench;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  opnd_i = '0;
    logic [4:0]    imm_amt_i = '0;
    logic [W-1:0]  reg_amt_i = '0;
    logic          amt_sel_i = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic [W-1:0]  res_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    funnel_shifter u_funnel_shifter (
        .opnd_i   (opnd_i),
        .imm_amt_i(imm_amt_i),
        .reg_amt_i(reg_amt_i),
        .amt_sel_i(amt_sel_i),
        .op_i     (op_i),
        .res_o    (res_o)
    );

    function automatic logic [W-1:0] ref_shift(input logic [1:0] op,
                                               input logic [W-1:0] a,
                                               input int k);
        case (op)
            2'b00:   return a >> k;
            2'b01:   return $unsigned($signed(a) >>> k);
            2'b10:   return a << k;
            default: return (k == 0) ? a : ((a >> k) | (a << (W - k)));
        endcase
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                         input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%0d amt_sel=%0d imm=%0d reg=%h opnd=%h actual=%h expected=%h",
                     tag, op_i, amt_sel_i, imm_amt_i, reg_amt_i, opnd_i, act, exp);
        end
    endtask

    logic [W-1:0] pats [8];

    initial begin
        pats[0] = 32'h0000_0001;
        pats[1] = 32'h8000_0000;
        pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h1234_5678;
        pats[4] = 32'h8765_4321;
        pats[5] = 32'hA5A5_5A5A;
        pats[6] = 32'h7FFF_FFFE;
        pats[7] = 32'h0F00_F00F;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle inputs: zero operand gives zero result (R1, k = 0 path of R5)
        check(res_o, 32'h0, "R1 idle");

        for (int p = 0; p < 8; p++) begin
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < W; k++) begin
                    for (int src = 0; src < 2; src++) begin
                        @(negedge clk);
                        opnd_i    = pats[p];
                        op_i      = 2'(op);
                        amt_sel_i = src[0];
                        if (src == 0) begin
                            imm_amt_i = 5'(k);
                            reg_amt_i = 32'hDEAD_BEE0 ^ {27'(p * 977 + op), 5'(31 - k)};
                        end else begin
                            imm_amt_i = 5'(31 - k);
                            reg_amt_i = {27'h5A5_A5A5 ^ 27'(p * 131 + k), 5'(k)};
                        end
                        #1;
                        if (k == 0)
                            check(res_o, pats[p], "R5 zero amount");
                        else if (src == 1)
                            check(res_o, ref_shift(2'(op), pats[p], k), "R6 register amount");
                        else
                            check(res_o, ref_shift(2'(op), pats[p], k), op_tag(2'(op)));
                        if (op == 3) begin
                            total++;
                            if ($countones(res_o) != $countones(pats[p])) begin
                                bad++;
                                $display("FAIL R7 popcount actual=%0d expected=%0d",
                                         $countones(res_o), $countones(pats[p]));
                            end
                        end
                    end
                end
            end
        end

        // R6: upper register bits alone change, result must not
        @(negedge clk);
        opnd_i = 32'hC3C3_0F0F; op_i = 2'b11; amt_sel_i = 1'b1;
        reg_amt_i = 32'h0000_0007;
        #1 check(res_o, ref_shift(2'b11, 32'hC3C3_0F0F, 7), "R6 base");
        reg_amt_i = 32'hFFFF_FFE7;
        #1 check(res_o, ref_shift(2'b11, 32'hC3C3_0F0F, 7), "R6 upper bits ignored");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule